// File: doc/BRIEF.md
# Ampere-Balance Dwell Time Calculator

This block computes, once per switching period, the conduction time of each of the nine switches in a current-source converter whose middle row of three switches is shared between a rectifier bridge and an inverter bridge. It receives six signed fixed-point current references, already divided by the dc-link current: three for the rectifier phases and three for the inverter phases. It also receives the switching period in clock ticks and the angle of the rectifier reference. From the angle it picks a 60-degree rectifier sector. It gives one upper-row switch the whole period and the other two upper switches no time. It then solves the ampere-balance relations for the middle row and the lower row.

A controller pulses `start_i` once per period with stable inputs. A fixed number of cycles later, `done_o` marks a fresh set of nine signed tick counts and the sector number. The lower-row times depend on both the rectifier and the inverter references because the middle row is shared, so they may be negative. They are passed on unmodified, and a later stage can detect and correct them.

Top module: `ab_dwell_calc`

## Requirements
- R1: While reset is held, and after its release until the first result, `done_o` is 0, all nine time outputs are 0 and `sector_o` is 1.
- R2: With a 16-bit angle where 65536 equals a full turn, let v = 12 × angle. Sector 1 covers v < 65536 or v ≥ 720896. Sector s (2 to 6) covers 65536·(2s−3) ≤ v < 65536·(2s−1).
- R3: The upper-row time of phase index (s−1) mod 3 (0 = a, 1 = b, 2 = c) equals the period. The other two upper-row times are 0.
- R4: Each phase term is ref × period / 32768 with ref in signed Q1.15, rounded to nearest. Halves go toward +∞, so the term is floor((ref·period + 16384) / 32768).
- R5: For each phase, middle time = upper time − rectifier term.
- R6: For each phase, lower time = middle time + inverter term. It is never clamped, and negative results are output as they are.
- R7: `done_o` is a one-cycle pulse on the 7th rising edge after the edge that samples `start_i`. Outputs hold their values until the next such pulse.
- R8: A `start_i` pulse while a computation is in progress is ignored. The running result is unaffected and no extra `done_o` follows.
- R9: With the period limited to 13 bits (0 to 8191), every result fits the 16-bit signed outputs without wrapping, including full-scale references of −32768 and +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one computation |
| period_i | input | 13 | Switching period in ticks |
| angle_i | input | 16 | Rectifier reference angle, full scale = 2π |
| rect_a_i | input | 16 | Rectifier phase-a reference, signed Q1.15 |
| rect_b_i | input | 16 | Rectifier phase-b reference, signed Q1.15 |
| rect_c_i | input | 16 | Rectifier phase-c reference, signed Q1.15 |
| inv_a_i | input | 16 | Inverter phase-a reference, signed Q1.15 |
| inv_b_i | input | 16 | Inverter phase-b reference, signed Q1.15 |
| inv_c_i | input | 16 | Inverter phase-c reference, signed Q1.15 |
| done_o | output | 1 | Result-valid strobe |
| sector_o | output | 3 | Rectifier sector, 1 to 6 |
| up_a_o | output | 16 | Upper-row time, phase a (signed ticks) |
| up_b_o | output | 16 | Upper-row time, phase b |
| up_c_o | output | 16 | Upper-row time, phase c |
| mid_a_o | output | 16 | Middle-row (shared) time, phase a |
| mid_b_o | output | 16 | Middle-row time, phase b |
| mid_c_o | output | 16 | Middle-row time, phase c |
| low_a_o | output | 16 | Lower-row time, phase a |
| low_b_o | output | 16 | Lower-row time, phase b |
| low_c_o | output | 16 | Lower-row time, phase c |

## Verification
The assertions check every cycle that:
- `done_o` never lasts more than one cycle.
- Any published sector lies between 1 and 6.
- Exactly one upper-row time equals the period while the other two are zero.
- The captured inputs stay frozen while a computation runs.
- No scaled term exceeds the period in magnitude.

Only the bench scenarios can show the rest:
- the exact sector boundaries;
- the rounding of half-tick products;
- the middle-row and lower-row values, including negative lower-row times;
- the seven-cycle latency;
- that a second start pulse during a computation leaves the result unchanged.

// File: rtl/ab_dwell_pkg.sv
`timescale 1ns/1ps
package ab_dwell_pkg;
  localparam int NUM_PH  = 3;
  localparam int NUM_REF = 2 * NUM_PH;
  localparam int SEC_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL   = 2'd1,
    ST_SOLVE = 2'd2
  } ab_state_e;
endpackage

// File: rtl/ab_sector_decode.sv
`timescale 1ns/1ps
// Maps an unsigned angle (full scale = one turn) onto one of six 60-degree
// sectors. Boundaries sit at odd multiples of 1/12 turn and are compared
// exactly by scaling the angle by 12 instead of rounding boundary constants.
module ab_sector_decode
  import ab_dwell_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic [ANGLE_W-1:0] angle_i,
  output logic [SEC_W-1:0]   sector_o
);
  localparam int PROD_W = ANGLE_W + 4;
  localparam int NUM_EDGE = 6;

  logic [PROD_W-1:0]   scaled;
  logic [NUM_EDGE-1:0] passed;
  logic [SEC_W-1:0]    n_passed;

  assign scaled = PROD_W'(angle_i) * PROD_W'(12);

  for (genvar k = 0; k < NUM_EDGE; k++) begin : g_edge
    localparam logic [PROD_W-1:0] EDGE = PROD_W'(2 * k + 1) << ANGLE_W;
    assign passed[k] = (scaled >= EDGE);
  end

  always_comb begin
    n_passed = '0;
    for (int k = 0; k < NUM_EDGE; k++) begin
      n_passed = n_passed + SEC_W'(passed[k]);
    end
  end

  assign sector_o = ((n_passed == '0) || (n_passed == SEC_W'(NUM_EDGE)))
                    ? SEC_W'(1) : (n_passed + SEC_W'(1));
endmodule

// File: rtl/ab_scale.sv
`timescale 1ns/1ps
// Multiplies a signed fractional reference by the period and rounds the
// product to the nearest tick (halves toward +inf).
module ab_scale #(
  parameter int REF_W    = 16,
  parameter int PERIOD_W = 13,
  parameter int TIME_W   = 16
) (
  input  logic [REF_W-1:0]    ref_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [TIME_W-1:0]   term_o
);
  localparam int PROD_W = REF_W + PERIOD_W + 1;
  localparam int FRAC   = REF_W - 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC - 1);

  logic signed [PROD_W-1:0] ref_ext;
  logic signed [PROD_W-1:0] per_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;

  assign ref_ext = $signed({{(PROD_W-REF_W){ref_i[REF_W-1]}}, ref_i});
  assign per_ext = $signed({{(PROD_W-PERIOD_W){1'b0}}, period_i});
  assign prod    = ref_ext * per_ext;
  assign biased  = prod + HALF;
  assign term_o  = TIME_W'(biased >>> FRAC);
endmodule

// File: rtl/ab_row_solve.sv
`timescale 1ns/1ps
// Seeds the upper row from the sector and solves the balance relations for
// the shared middle row and the lower row. Lower-row values are not clamped.
module ab_row_solve
  import ab_dwell_pkg::*;
#(
  parameter int PERIOD_W = 13,
  parameter int TIME_W   = 16
) (
  input  logic [SEC_W-1:0]               sector_i,
  input  logic [PERIOD_W-1:0]            period_i,
  input  logic [NUM_PH-1:0][TIME_W-1:0]  rterm_i,
  input  logic [NUM_PH-1:0][TIME_W-1:0]  iterm_i,
  output logic [NUM_PH-1:0][TIME_W-1:0]  up_o,
  output logic [NUM_PH-1:0][TIME_W-1:0]  mid_o,
  output logic [NUM_PH-1:0][TIME_W-1:0]  low_o
);
  logic [1:0] full_ph;

  assign full_ph = (sector_i >= SEC_W'(4)) ? 2'(sector_i - SEC_W'(4))
                                           : 2'(sector_i - SEC_W'(1));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    assign up_o[p]  = (full_ph == 2'(p)) ? TIME_W'(period_i) : '0;
    assign mid_o[p] = up_o[p] - rterm_i[p];
    assign low_o[p] = mid_o[p] + iterm_i[p];
  end
endmodule

// File: rtl/ab_dwell_calc.sv
`timescale 1ns/1ps
module ab_dwell_calc
  import ab_dwell_pkg::*;
#(
  parameter int REF_W   = 16,
  parameter int TIME_W  = 16,
  parameter int ANGLE_W = 16,
  parameter int PERIOD_W = TIME_W - 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [PERIOD_W-1:0]      period_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  input  logic signed [REF_W-1:0]  rect_a_i,
  input  logic signed [REF_W-1:0]  rect_b_i,
  input  logic signed [REF_W-1:0]  rect_c_i,
  input  logic signed [REF_W-1:0]  inv_a_i,
  input  logic signed [REF_W-1:0]  inv_b_i,
  input  logic signed [REF_W-1:0]  inv_c_i,
  output logic                     done_o,
  output logic [SEC_W-1:0]         sector_o,
  output logic signed [TIME_W-1:0] up_a_o,
  output logic signed [TIME_W-1:0] up_b_o,
  output logic signed [TIME_W-1:0] up_c_o,
  output logic signed [TIME_W-1:0] mid_a_o,
  output logic signed [TIME_W-1:0] mid_b_o,
  output logic signed [TIME_W-1:0] mid_c_o,
  output logic signed [TIME_W-1:0] low_a_o,
  output logic signed [TIME_W-1:0] low_b_o,
  output logic signed [TIME_W-1:0] low_c_o
);
  localparam int IDX_W = $clog2(NUM_REF);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ab_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic cap_en, mul_en, out_en;

  logic [PERIOD_W-1:0]             period_q;
  logic [ANGLE_W-1:0]              angle_q;
  logic [NUM_REF-1:0][REF_W-1:0]   ref_in, ref_q;
  logic [NUM_REF-1:0][TIME_W-1:0]  term_q;
  logic [TIME_W-1:0]               scaled;
  logic [SEC_W-1:0]                sector_d, sector_q;
  logic [NUM_PH-1:0][TIME_W-1:0]   up_d, mid_d, low_d;
  logic [NUM_PH-1:0][TIME_W-1:0]   up_q, mid_q, low_q;
  logic                            done_q;

  // index 0..2 rectifier a..c, 3..5 inverter a..c
  assign ref_in = {inv_c_i, inv_b_i, inv_a_i, rect_c_i, rect_b_i, rect_a_i};

  // one shared multiplier, one reference per cycle
  ab_scale #(.REF_W(REF_W), .PERIOD_W(PERIOD_W), .TIME_W(TIME_W)) u_scale (
    .ref_i    (ref_q[idx_q]),
    .period_i (period_q),
    .term_o   (scaled)
  );

  ab_sector_decode #(.ANGLE_W(ANGLE_W)) u_sector (
    .angle_i  (angle_q),
    .sector_o (sector_d)
  );

  ab_row_solve #(.PERIOD_W(PERIOD_W), .TIME_W(TIME_W)) u_solve (
    .sector_i (sector_d),
    .period_i (period_q),
    .rterm_i  (term_q[NUM_PH-1:0]),
    .iterm_i  (term_q[NUM_REF-1:NUM_PH]),
    .up_o     (up_d),
    .mid_o    (mid_d),
    .low_o    (low_d)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    mul_en  = 1'b0;
    out_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          idx_d   = '0;
          state_d = ST_MUL;
        end
      end
      ST_MUL: begin
        mul_en = 1'b1;
        if (idx_q == IDX_W'(NUM_REF - 1)) state_d = ST_SOLVE;
        else                              idx_d   = idx_q + IDX_W'(1);
      end
      ST_SOLVE: begin
        out_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      period_q <= '0;
      angle_q  <= '0;
      ref_q    <= '0;
      term_q   <= '0;
      sector_q <= SEC_W'(1);
      up_q     <= '0;
      mid_q    <= '0;
      low_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= out_en;
      if (cap_en) begin
        period_q <= period_i;
        angle_q  <= angle_i;
        ref_q    <= ref_in;
      end
      if (mul_en) term_q[idx_q] <= scaled;
      if (out_en) begin
        sector_q <= sector_d;
        up_q     <= up_d;
        mid_q    <= mid_d;
        low_q    <= low_d;
      end
    end
  end

  assign done_o   = done_q;
  assign sector_o = sector_q;
  assign up_a_o   = up_q[0];
  assign up_b_o   = up_q[1];
  assign up_c_o   = up_q[2];
  assign mid_a_o  = mid_q[0];
  assign mid_b_o  = mid_q[1];
  assign mid_c_o  = mid_q[2];
  assign low_a_o  = low_q[0];
  assign low_b_o  = low_q[1];
  assign low_c_o  = low_q[2];

  // ---------------- assertions ----------------
  logic signed [TIME_W-1:0] period_s;
  logic [NUM_PH-1:0]        up_full, up_zero;

  assign period_s = TIME_W'(period_q);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_upchk
    assign up_full[p] = (up_q[p] == TIME_W'(period_q));
    assign up_zero[p] = (up_q[p] == '0);
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |=> !done_o);

  assert_sector_range_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |-> (sector_o >= SEC_W'(1)) && (sector_o <= SEC_W'(6)));

  assert_upper_seed_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done_o && period_q != '0) |-> ($countones(up_full) == 1) && ($countones(up_zero) == 2));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q != ST_IDLE) |=> ($stable(period_q) && $stable(angle_q) && $stable(ref_q)));

  for (genvar k = 0; k < NUM_REF; k++) begin : g_bound
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
      (state_q == ST_SOLVE) |-> (($signed(term_q[k]) <= period_s) &&
                                 ($signed(term_q[k]) >= -period_s)));
  end
endmodule

// File: tb/ab_dwell_calc_tb_top.sv
`timescale 1ns/1ps
module ab_dwell_calc_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [12:0] period_i;
  logic [15:0] angle_i;
  logic signed [15:0] rect_a_i, rect_b_i, rect_c_i, inv_a_i, inv_b_i, inv_c_i;
  logic done_o;
  logic [2:0] sector_o;
  logic signed [15:0] up_a_o, up_b_o, up_c_o, mid_a_o, mid_b_o, mid_c_o;
  logic signed [15:0] low_a_o, low_b_o, low_c_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ab_dwell_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .angle_i(angle_i), .rect_a_i(rect_a_i), .rect_b_i(rect_b_i),
    .rect_c_i(rect_c_i), .inv_a_i(inv_a_i), .inv_b_i(inv_b_i),
    .inv_c_i(inv_c_i), .done_o(done_o), .sector_o(sector_o),
    .up_a_o(up_a_o), .up_b_o(up_b_o), .up_c_o(up_c_o),
    .mid_a_o(mid_a_o), .mid_b_o(mid_b_o), .mid_c_o(mid_c_o),
    .low_a_o(low_a_o), .low_b_o(low_b_o), .low_c_o(low_c_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sector(input int ang);
    int v = 12 * ang;
    if (v < 65536 || v >= 11 * 65536) return 1;
    return 2 + (v - 65536) / 131072;
  endfunction

  function automatic int exp_term(input int r, input int per);
    longint p = longint'(r) * longint'(per) + 64'sd16384;
    return int'(p >>> 15);
  endfunction

  int e_sec;
  int e_up[3], e_mid[3], e_low[3];

  task automatic expect_of(input int ang, input int per, input int r[6]);
    int sel;
    e_sec = exp_sector(ang);
    sel = (e_sec - 1) % 3;
    for (int p = 0; p < 3; p++) begin
      e_up[p]  = (p == sel) ? per : 0;
      e_mid[p] = e_up[p] - exp_term(r[p], per);
      e_low[p] = e_mid[p] + exp_term(r[p+3], per);
    end
  endtask

  task automatic compare_outputs(input string tag);
    int a_up[3], a_mid[3], a_low[3];
    a_up  = '{int'(up_a_o),  int'(up_b_o),  int'(up_c_o)};
    a_mid = '{int'(mid_a_o), int'(mid_b_o), int'(mid_c_o)};
    a_low = '{int'(low_a_o), int'(low_b_o), int'(low_c_o)};
    chk("R2", {tag, " sector"}, int'(sector_o), e_sec);
    for (int p = 0; p < 3; p++) begin
      chk("R3", $sformatf("%s up[%0d]", tag, p), a_up[p], e_up[p]);
      chk("R5", $sformatf("%s mid[%0d]", tag, p), a_mid[p], e_mid[p]);
      chk("R6", $sformatf("%s low[%0d]", tag, p), a_low[p], e_low[p]);
    end
  endtask

  task automatic drive(input int ang, input int per, input int r[6]);
    angle_i  = 16'(ang);
    period_i = 13'(per);
    rect_a_i = 16'(r[0]); rect_b_i = 16'(r[1]); rect_c_i = 16'(r[2]);
    inv_a_i  = 16'(r[3]); inv_b_i  = 16'(r[4]); inv_c_i  = 16'(r[5]);
  endtask

  // inject=1 pulses a second start with other inputs during the computation
  task automatic run_case(input string tag, input int ang, input int per,
                          input int r[6], input bit inject);
    int lat;
    int other[6] = '{100, -200, 300, -400, 500, -600};
    expect_of(ang, per, r);
    @(negedge clk);
    drive(ang, per, r);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 30) begin
      @(negedge clk);
      lat++;
      if (inject && lat == 2) begin
        drive((ang + 30000) % 65536, (per + 1000) % 8192, other);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk("R7", {tag, " latency"}, lat, 7);
    compare_outputs(tag);
    @(negedge clk);
    chk("R7", {tag, " done width"}, int'(done_o), 0);
    if (inject) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (done_o) chk("R8", {tag, " extra done"}, 1, 0);
      end
      chk("R8", {tag, " no extra done"}, int'(done_o), 0);
      compare_outputs({tag, " held"});
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r[6];
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0;
    drive(0, 0, '{0, 0, 0, 0, 0, 0});
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "done in reset", int'(done_o), 0);
    chk("R1", "sector in reset", int'(sector_o), 1);
    chk("R1", "up_a in reset", int'(up_a_o), 0);
    chk("R1", "low_c in reset", int'(low_c_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "done after release", int'(done_o), 0);
    chk("R1", "mid_b after release", int'(mid_b_o), 0);

    // R2: sector boundaries
    run_case("R2 ang0",     0,     5000, '{1000, -2000, 1000, 3000, -1000, -2000}, 0);
    run_case("R2 ang5461",  5461,  5000, '{1000, -2000, 1000, 3000, -1000, -2000}, 0);
    run_case("R2 ang5462",  5462,  5000, '{1000, -2000, 1000, 3000, -1000, -2000}, 0);
    run_case("R2 ang16384", 16384, 5000, '{-500, 2500, -2000, 0, 0, 0}, 0);
    run_case("R2 ang60074", 60074, 5000, '{-500, 2500, -2000, 0, 0, 0}, 0);
    run_case("R2 ang60075", 60075, 5000, '{-500, 2500, -2000, 0, 0, 0}, 0);
    run_case("R2 ang65535", 65535, 5000, '{-500, 2500, -2000, 0, 0, 0}, 0);

    // R4: half-tick rounding, +0.5 -> 1 and -0.5 -> 0
    run_case("R4 halves", 0, 4096, '{4, -4, 0, -4, 4, 0}, 0);

    // R9 and R6: full-scale references, negative lower-row times
    run_case("R9 max", 0, 8191, '{-32768, 32767, 32767, 32767, -32768, -32768}, 0);
    run_case("R6 negative", 40000, 8191, '{0, 0, 32767, -32768, -32768, 0}, 0);

    // R8: start while busy is ignored
    run_case("R8 busy start", 20000, 3000, '{7000, -3000, -4000, 1200, 9000, -10200}, 1);

    // random cases
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 6; k++) r[k] = int'($signed(16'($urandom)));
      run_case($sformatf("rand%0d", n), int'($urandom % 65536),
               int'($urandom % 8192), r, 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule